// File: doc/BRIEF.md
# Suspendable System Clock Divider

This block sits beside a small microcontroller core and turns a free-running base oscillator clock into a system clock enable. The enable is one base-clock-wide pulse that repeats every 1, 2, 4 or 8 base cycles. Logic that runs on the base clock qualifies its flops with this pulse. Software picks the ratio through a control byte. The base clock keeps running at all times, so the block can watch for wake events while the system clock is stopped.

Setting the suspend bit in the control byte stops the pulses. They stay stopped until one of four wake sources fires:

- a port-0 match,
- a port-1 match,
- a timer-3 overflow,
- comparator 0 being enabled with its output low.

No interrupt enable takes part in this decision. All wake inputs are asynchronous and are synchronized to the base clock before use.

A second byte holds a 7-bit oscillator trim value. It is readable and writable by software, and it drives a port toward the analog oscillator: lower codes make the oscillator faster, higher codes make it slower.

Top module: `sysclk_ctrl`

## Requirements
- R1: With divide select s (0, 1, 2, 3) in control bits [1:0], `sys_en` is high for exactly one base cycle in every 2^s base cycles (ratios 1, 2, 4, 8).
- R2: After reset:
  - the divide select is 3 (divide by 8);
  - `suspended` is 0;
  - the trim value equals parameter `CAL_INIT`;
  - `sys_en` is high in the first cycle after reset is released.
- R3: A control write with bit 5 set raises `suspended` after that clock edge. A control write with bit 5 clear never lowers it.
- R4: While `suspended` is high, `sys_en` stays low.
- R5: `suspended` clears only on a qualified wake. The qualified wakes are `wake_p0`, `wake_p1`, `tmr3_ovf`, or `cmp0_en` high together with `cmp0_out` low. If an input is asserted before base edge k, `suspended` is low after edge k+2. A low comparator output with `cmp0_en` low does not wake.
- R6: In the first cycle where `suspended` is low again, `sys_en` is high. Pulses then continue at the ratio currently selected.
- R7: The trim byte (`reg_sel`=1) stores bits [6:0] of a write. It reads back with bit 7 at 0, and `cal_out` always shows the stored value.
- R8: A new divide select takes effect only after the pulse period in progress ends. No period is cut short.
- R9: A control read returns the divide select in bits [1:0] and the suspend state in bit 5. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running base oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control byte, 1 selects trim byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected byte |
| wake_p0 | input | 1 | Port-0 match event (asynchronous) |
| wake_p1 | input | 1 | Port-1 match event (asynchronous) |
| cmp0_en | input | 1 | Comparator 0 enable (asynchronous) |
| cmp0_out | input | 1 | Comparator 0 output (asynchronous) |
| tmr3_ovf | input | 1 | Timer-3 overflow event (asynchronous) |
| sys_en | output | 1 | System clock enable pulse |
| suspended | output | 1 | High while the system clock is halted |
| cal_out | output | 7 | Oscillator trim value |

## Verification
The assertions assume three things:

- Every wake input is held for at least one full base cycle, so the synchronizer captures it.
- A fall of `suspended` is always traced to a synchronized wake level seen one cycle earlier.
- A rise of `suspended` is always traced to a register write carrying bit 5.

The stimulus respects these by changing inputs only on the falling base edge and holding wake sources for whole cycles. After each wake it releases the source and waits several cycles, so the synchronizer is empty before the next suspend. One case deliberately keeps a wake source active across a suspend write, to confirm that an immediate re-wake still passes through the synchronizer.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
   // positions of the raw wake inputs inside the synchronized vector
   localparam int WK_P0   = 0;
   localparam int WK_P1   = 1;
   localparam int WK_CEN  = 2;
   localparam int WK_COUT = 3;
   localparam int WK_T3   = 4;
   localparam int WK_N    = 5;

   typedef enum logic { SEL_CTRL = 1'b0, SEL_TRIM = 1'b1 } reg_sel_e;
endpackage

// File: rtl/sysclk_sync.sv
module sysclk_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sysclk_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sysclk_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= '0;
      else        pipe[0] <= d_async;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[i] <= '0;
         else        pipe[i] <= pipe[i-1];
      end
   end

   assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/sysclk_wake.sv
module sysclk_wake
   import sysclk_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [WK_N-1:0] raw,
   output logic            wake
);
   logic [WK_N-1:0] s;

   sysclk_sync #(.WIDTH(WK_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw),
      .q_sync  (s)
   );

   // comparator wakes only when enabled and its output is low
   logic cmp_wake;
   assign cmp_wake = s[WK_CEN] & ~s[WK_COUT];
   assign wake     = s[WK_P0] | s[WK_P1] | s[WK_T3] | cmp_wake;
endmodule

// File: rtl/sysclk_div.sv
module sysclk_div #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             en_o
);
   localparam int CNT_W = (1 << SEL_W) - 1;
   localparam logic [SEL_W-1:0] SEL_SLOW = {SEL_W{1'b1}};

   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("sysclk_div: SEL_W must be 1..3");
   end

   logic [SEL_W-1:0] act;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] term;

   assign term = (CNT_W'(1) << act) - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= SEL_SLOW;
         cnt <= '0;
      end else if (!run) begin
         // park at a boundary so restart begins a fresh period
         act <= sel;
         cnt <= '0;
      end else if (cnt == term) begin
         act <= sel;
         cnt <= '0;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   assign en_o = run && (cnt == '0);
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
   import sysclk_pkg::*;
#(
   parameter int          DATA_W      = 8,
   parameter int          SEL_W       = 2,
   parameter int          CAL_W       = 7,
   parameter int          SUSP_BIT    = 5,
   parameter int          SYNC_STAGES = 2,
   parameter logic [6:0]  CAL_INIT    = 7'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              wake_p0,
   input  logic              wake_p1,
   input  logic              cmp0_en,
   input  logic              cmp0_out,
   input  logic              tmr3_ovf,
   output logic              sys_en,
   output logic              suspended,
   output logic [CAL_W-1:0]  cal_out
);
   localparam logic [SEL_W-1:0] SEL_RESET = {SEL_W{1'b1}};

   if (CAL_W >= DATA_W) begin : g_bad_cal
      $error("sysclk_ctrl: trim field must leave bit 7 spare");
   end
   if (SUSP_BIT >= DATA_W || SUSP_BIT < SEL_W) begin : g_bad_susp
      $error("sysclk_ctrl: suspend bit overlaps or is out of range");
   end
   if (CAL_W > 7) begin : g_bad_init
      $error("sysclk_ctrl: CAL_INIT is 7 bits wide");
   end

   logic             ctl_wr, trim_wr, wake, run;
   logic [SEL_W-1:0] div_sel;
   logic [CAL_W-1:0] trim;
   logic             susp;

   assign ctl_wr  = reg_wr && (reg_sel == SEL_CTRL);
   assign trim_wr = reg_wr && (reg_sel == SEL_TRIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_sel <= SEL_RESET;
         trim    <= CAL_INIT[CAL_W-1:0];
      end else begin
         if (ctl_wr)  div_sel <= reg_wdata[SEL_W-1:0];
         if (trim_wr) trim    <= reg_wdata[CAL_W-1:0];
      end
   end

   // set by software, cleared only by a qualified wake
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          susp <= 1'b0;
      else if (ctl_wr && reg_wdata[SUSP_BIT]) susp <= 1'b1;
      else if (susp && wake)               susp <= 1'b0;
   end

   sysclk_wake #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   ({tmr3_ovf, cmp0_out, cmp0_en, wake_p1, wake_p0}),
      .wake  (wake)
   );

   assign run = ~susp;

   sysclk_div #(.SEL_W(SEL_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .sel   (div_sel),
      .en_o  (sys_en)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_sel == SEL_TRIM) begin
         reg_rdata[CAL_W-1:0] = trim;
      end else begin
         reg_rdata[SEL_W-1:0] = div_sel;
         reg_rdata[SUSP_BIT]  = susp;
      end
   end

   assign suspended = susp;
   assign cal_out   = trim;

   // R3: a suspend can only start from a control write carrying the bit
   p_susp_from_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspended) |-> $past(reg_wr && !reg_sel && reg_wdata[SUSP_BIT]));

   // R4: no enable is issued while halted
   p_quiet_when_halted_r4: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |-> !sys_en);

   // R5: leaving suspend needs a synchronized wake one cycle earlier
   p_wake_needed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(suspended) |-> $past(wake));

   // R6: the divider restarts at a period boundary with an immediate pulse
   p_restart_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(suspended) |-> sys_en);

   // R7: the trim output only moves after a trim write
   p_trim_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_sel) |=> $stable(cal_out));
endmodule

// File: tb/sysclk_ctrl_test.sv
module sysclk_ctrl_test;
   localparam logic [6:0] INIT = 7'h40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_sel = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       wake_p0 = 1'b0, wake_p1 = 1'b0, cmp0_en = 1'b0, cmp0_out = 1'b1, tmr3_ovf = 1'b0;
   logic       sys_en, suspended;
   logic [6:0] cal_out;

   int    total = 0, bad = 0;
   string phase = "R2";
   bit    done = 1'b0;

   sysclk_ctrl #(.CAL_INIT(INIT)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .wake_p0(wake_p0), .wake_p1(wake_p1), .cmp0_en(cmp0_en),
      .cmp0_out(cmp0_out), .tmr3_ovf(tmr3_ovf),
      .sys_en(sys_en), .suspended(suspended), .cal_out(cal_out)
   );

   always #10 clk = ~clk;

   task automatic chk(string tag, string what, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
      end
   endtask

   // behavioural reference: period position, pending ratio, halt flag, wake delay line
   int       m_sel, m_act, m_pos, m_trim;
   bit       m_halt;
   bit [4:0] d1, d2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sel = 3; m_act = 3; m_pos = 0; m_halt = 0; m_trim = INIT; d1 = '0; d2 = '0;
      end else begin
         bit wk;
         wk = d2[0] | d2[1] | d2[4] | (d2[2] & ~d2[3]);
         if (m_halt) begin
            m_pos = 0; m_act = m_sel;
         end else if (m_pos == (1 << m_act) - 1) begin
            m_pos = 0; m_act = m_sel;
         end else begin
            m_pos++;
         end
         if (reg_wr && !reg_sel && reg_wdata[5]) m_halt = 1;
         else if (m_halt && wk)                  m_halt = 0;
         if (reg_wr && !reg_sel) m_sel  = int'(reg_wdata[1:0]);
         if (reg_wr && reg_sel)  m_trim = int'(reg_wdata[6:0]);
         d2 = d1;
         d1 = {tmr3_ovf, cmp0_out, cmp0_en, wake_p1, wake_p0};
      end
   end

   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         int exp_rd;
         exp_rd = reg_sel ? m_trim : ((m_halt ? 32 : 0) + m_sel);
         chk(phase, "sys_en", int'(sys_en), int'(!m_halt && m_pos == 0));
         chk(phase, "suspended", int'(suspended), int'(m_halt));
         chk("R7", "cal_out", int'(cal_out), m_trim);
         chk(phase, "reg_rdata", int'(reg_rdata), exp_rd);
      end
   end

   task automatic wr(bit sel, logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(bit sel, int exp, string tag);
      @(negedge clk);
      reg_sel = sel;
      #1;
      chk(tag, "readback", int'(reg_rdata), exp);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_en(int n, int exp, string tag);
      int hits = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (sys_en) hits++;
      end
      chk(tag, "enable count", hits, exp);
   endtask

   task automatic set_src(int src, bit on);
      case (src)
         0: wake_p0 = on;
         1: wake_p1 = on;
         2: begin cmp0_en = on; cmp0_out = !on; end
         default: tmr3_ovf = on;
      endcase
   endtask

   // halt, confirm silence, fire one source, check latency and restart
   task automatic wake_cycle(int src);
      phase = "R3";
      wr(1'b0, 8'h21);
      chk("R3", "suspended after write", int'(suspended), 1);
      phase = "R4";
      count_en(20, 0, "R4");
      phase = "R5";
      set_src(src, 1'b1);
      @(negedge clk);
      chk("R5", "still halted after 1 edge", int'(suspended), 1);
      @(negedge clk);
      chk("R5", "still halted after 2 edges", int'(suspended), 1);
      @(negedge clk);
      chk("R5", "released after 3 edges", int'(suspended), 0);
      chk("R6", "restart pulse", int'(sys_en), 1);
      set_src(src, 1'b0);
      phase = "R6";
      idle(6);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      #1;
      chk("R2", "suspended at reset", int'(suspended), 0);
      chk("R2", "first enable", int'(sys_en), 1);
      chk("R2", "trim at reset", int'(cal_out), int'(INIT));
      chk("R2", "control at reset", int'(reg_rdata), 8'h03);
      count_en(64, 8, "R2");

      phase = "R1";
      for (int s = 0; s < 4; s++) begin
         wr(1'b0, 8'(s));
         idle(10);
         count_en(64, 64 >> s, "R1");
      end

      phase = "R8";
      wr(1'b0, 8'h00);
      idle(3);
      wr(1'b0, 8'h03);
      idle(5);
      wr(1'b0, 8'h01);
      idle(12);
      wr(1'b0, 8'h02);
      idle(1);
      wr(1'b0, 8'h00);
      idle(10);

      phase = "R7";
      wr(1'b1, 8'hFF);
      rd(1'b1, 8'h7F, "R7");
      wr(1'b1, 8'h00);
      rd(1'b1, 8'h00, "R7");
      wr(1'b1, 8'hD5);
      rd(1'b1, 8'h55, "R7");

      phase = "R9";
      wr(1'b0, 8'hDE);
      rd(1'b0, 8'h02, "R9");
      wr(1'b0, 8'h1D);
      rd(1'b0, 8'h01, "R9");

      // a clear-bit write and a disabled comparator must not release the halt
      phase = "R3";
      wr(1'b0, 8'h21);
      rd(1'b0, 8'h21, "R9");
      wr(1'b0, 8'h01);
      chk("R3", "zero write keeps halt", int'(suspended), 1);
      phase = "R5";
      cmp0_en = 1'b0; cmp0_out = 1'b0;
      idle(8);
      chk("R5", "disabled comparator ignored", int'(suspended), 1);
      cmp0_out = 1'b1;
      wake_p0 = 1'b1;
      idle(4);
      wake_p0 = 1'b0;
      chk("R6", "released by port 0", int'(suspended), 0);
      idle(6);

      for (int src = 0; src < 4; src++) wake_cycle(src);

      // wake already active when the halt is written
      phase = "R5";
      wr(1'b0, 8'h02);
      tmr3_ovf = 1'b1;
      idle(4);
      wr(1'b0, 8'h22);
      @(negedge clk);
      chk("R5", "immediate re-wake", int'(suspended), 0);
      tmr3_ovf = 1'b0;
      idle(20);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule